// File: doc/BRIEF.md
# Registered Sixteen-Function 4-Bit ALU

This block is a small arithmetic and logic unit. A 4-bit function code picks one of sixteen operations on two 4-bit operands and a carry-in bit. The result goes into an output register. The register loads on a rising clock edge only while the enable input is high. With the enable low it keeps its last value, so a controller can present operands and a function code and collect the answer one clock later.

There are no status flags; the only output is the registered result. Arithmetic wraps around the operand width. The function code splits into two halves by its top bit. Codes 0 to 7 use one shared adder: transfer, increment, the two additions, subtraction, the two complements and decrement. Codes 8 to 15 are operand-B transfer, bitwise operations, shifts, parity and constant zero.

Top module: `alu4_core`

## Requirements
- R1: A synchronous active-high reset sets the result register to 0000 on the next rising edge, whatever the other inputs are.
- R2: While enable is low and reset is low, the result keeps its previous value across clock edges, whatever the function code and operands are.
- R3: While enable is high, the result seen after a rising edge is the operation selected by the function code sampled at that edge, applied to the operands sampled at that edge.
- R4: Code 0001 gives A+1, code 0010 gives A+B, code 0100 gives A−B and code 0111 gives A−1. All of them wrap modulo 16, and carry-in has no effect on them (A=1111 incremented gives 0000; A=0000 decremented gives 1111).
- R5: Code 0011 gives A+B+carry-in modulo 16 (A=0111, B=0011 gives 1010 with carry-in 0 and 1011 with carry-in 1).
- R6: Code 0000 passes A, code 1000 passes B, code 0101 gives the bitwise inverse of A, code 0110 gives (16−A) mod 16, and codes 1001, 1010, 1011 give A AND B, A OR B and A XOR B.
- R7: Code 1100 shifts A left by one and code 1101 shifts A right by one. Both are logical, with 0 entering the vacated bit, and carry-in has no effect on them.
- R8: Code 1110 gives 0 in bits 3..1 and, in bit 0, the XOR of all four bits of A.
- R9: Code 1111 gives 0000 for any operands and carry-in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Loads the result register when high |
| func | input | 4 | Function code selecting the operation |
| opa | input | 4 | Operand A |
| opb | input | 4 | Operand B |
| cin | input | 1 | Carry-in, used only by code 0011 |
| res | output | 4 | Registered result |

## Verification
The bench targets the wrap points: increment at 1111, decrement and negate at 0000, and subtraction with B larger than A. A design that widened or saturated would give values other than 0000, 1111 or the modular difference there. It runs every code with both carry-in values, which exposes a carry-in that leaks into plain add, increment or the shifts, and it checks that add-with-carry adds exactly one. It checks the shift fill bits and the parity bit on odd and even operands, which catches arithmetic shifts, rotates and an inverted parity. It also drops the enable with changing inputs, which catches a register that loads when it should hold.

// File: rtl/alu4_pkg.sv
package alu4_pkg;
  typedef enum logic [3:0] {
    FN_PASS_A = 4'h0, FN_INC   = 4'h1, FN_ADD  = 4'h2, FN_ADC  = 4'h3,
    FN_SUB    = 4'h4, FN_INV_A = 4'h5, FN_NEG  = 4'h6, FN_DEC  = 4'h7,
    FN_PASS_B = 4'h8, FN_AND   = 4'h9, FN_OR   = 4'hA, FN_XOR  = 4'hB,
    FN_SHL    = 4'hC, FN_SHR   = 4'hD, FN_PAR  = 4'hE, FN_ZERO = 4'hF
  } alu_fn_e;
  localparam int FN_W = 4;
endpackage

// File: rtl/alu4_arith.sv
module alu4_arith
  import alu4_pkg::*;
#(
  parameter int DATA_W = 4
) (
  input  logic [FN_W-2:0]   sel,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              cin,
  output logic [DATA_W-1:0] y
);
  logic [DATA_W-1:0] lhs, rhs;
  logic              c0;

  always_comb begin
    lhs = a;
    rhs = '0;
    c0  = 1'b0;
    unique case (sel)
      3'd0: ;
      3'd1: c0 = 1'b1;
      3'd2: rhs = b;
      3'd3: begin rhs = b; c0 = cin; end
      3'd4: begin rhs = ~b; c0 = 1'b1; end
      3'd5: lhs = ~a;
      3'd6: begin lhs = ~a; c0 = 1'b1; end
      default: rhs = '1;
    endcase
  end

  assign y = lhs + rhs + {{(DATA_W-1){1'b0}}, c0};
endmodule

// File: rtl/alu4_logic.sv
module alu4_logic
  import alu4_pkg::*;
#(
  parameter int DATA_W = 4
) (
  input  logic [FN_W-2:0]   sel,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] y
);
  always_comb begin
    unique case (sel)
      3'd0: y = b;
      3'd1: y = a & b;
      3'd2: y = a | b;
      3'd3: y = a ^ b;
      3'd4: y = {a[DATA_W-2:0], 1'b0};
      3'd5: y = {1'b0, a[DATA_W-1:1]};
      3'd6: y = {{(DATA_W-1){1'b0}}, ^a};
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/alu4_outreg.sv
module alu4_outreg #(
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] d,
  output logic [DATA_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/alu4_core.sv
module alu4_core
  import alu4_pkg::*;
#(
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [FN_W-1:0]   func,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic              cin,
  output logic [DATA_W-1:0] res
);
  logic [DATA_W-1:0] arith_y, logic_y, next_y;

  alu4_arith #(.DATA_W(DATA_W)) u_arith (
    .sel(func[FN_W-2:0]), .a(opa), .b(opb), .cin(cin), .y(arith_y)
  );

  alu4_logic #(.DATA_W(DATA_W)) u_logic (
    .sel(func[FN_W-2:0]), .a(opa), .b(opb), .y(logic_y)
  );

  assign next_y = func[FN_W-1] ? logic_y : arith_y;

  alu4_outreg #(.DATA_W(DATA_W)) u_reg (
    .clk(clk), .rst(rst), .load(en), .d(next_y), .q(res)
  );
endmodule

// File: rtl/alu4_core_chk.sv
module alu4_core_chk #(
  parameter int DATA_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              en,
  input logic [3:0]        func,
  input logic [DATA_W-1:0] opa,
  input logic [DATA_W-1:0] opb,
  input logic              cin,
  input logic [DATA_W-1:0] res
);
  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (res == '0));

  assert_hold_when_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(res));

  assert_pass_b_R6: assert property (@(posedge clk) disable iff (rst)
    (en && func == 4'h8) |=> (res == $past(opb)));

  assert_shift_fill_R7: assert property (@(posedge clk) disable iff (rst)
    (en && func == 4'hC) |=> (res[0] == 1'b0 && res[DATA_W-1:1] == $past(opa[DATA_W-2:0])));

  assert_parity_bit_R8: assert property (@(posedge clk) disable iff (rst)
    (en && func == 4'hE) |=> (res[DATA_W-1:1] == '0 && res[0] == $past(^opa)));

  assert_const_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (en && func == 4'hF) |=> (res == '0));
endmodule

bind alu4_core alu4_core_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .en(en), .func(func),
  .opa(opa), .opb(opb), .cin(cin), .res(res)
);

// File: tb/sim_alu4_core.sv
module sim_alu4_core;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en = 1'b0;
  logic [3:0] func = 4'h0;
  logic [3:0] opa = 4'h0;
  logic [3:0] opb = 4'h0;
  logic       cin = 1'b0;
  logic [3:0] res;

  int checks = 0;
  int errors = 0;
  logic [3:0] expect_q = 4'h0;

  always #10 clk = ~clk;

  alu4_core u0 (
    .clk(clk), .rst(rst), .en(en), .func(func),
    .opa(opa), .opb(opb), .cin(cin), .res(res)
  );

  function automatic logic [3:0] model(input int f, input int a, input int b, input int c);
    int r;
    int ones;
    case (f)
      0:  r = a;
      1:  r = a + 1;
      2:  r = a + b;
      3:  r = a + b + c;
      4:  r = a - b + 16;
      5:  r = 15 - a;
      6:  r = 16 - a;
      7:  r = a + 15;
      8:  r = b;
      9:  r = a & b;
      10: r = a | b;
      11: r = a ^ b;
      12: r = a * 2;
      13: r = a / 2;
      14: begin
        ones = 0;
        for (int i = 0; i < 4; i++) ones += (a >> i) & 1;
        r = ones % 2;
      end
      default: r = 0;
    endcase
    return 4'(r % 16);
  endfunction

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: res=%b expected=%b", req, act, exp);
    end
  endtask

  // Drive at the falling edge, let one rising edge pass, compare at the next falling edge.
  task automatic step(input string req, input logic e, input int f, input int a,
                      input int b, input int c);
    en = e; func = 4'(f); opa = 4'(a); opb = 4'(b); cin = c[0];
    @(posedge clk);
    if (e) expect_q = model(f, a, b, c);
    @(negedge clk);
    check(req, res, expect_q);
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: res=%b expected=done", res);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    en = 1'b1; func = 4'h2; opa = 4'h5; opb = 4'h6;
    @(negedge clk); @(negedge clk);
    check("R1 reset", res, 4'h0);
    rst = 1'b0;

    // R3/R4/R5/R6/R7/R9 with A=0111 B=0011
    step("R6 pass A", 1, 0, 7, 3, 0);
    step("R4 inc", 1, 1, 7, 3, 1);
    step("R4 add", 1, 2, 7, 3, 1);
    step("R5 adc c0", 1, 3, 7, 3, 0);
    check("R5 adc c0 value", res, 4'b1010);
    step("R5 adc c1", 1, 3, 7, 3, 1);
    check("R5 adc c1 value", res, 4'b1011);
    step("R4 sub", 1, 4, 7, 3, 0);
    step("R6 not", 1, 5, 7, 3, 0);
    step("R6 neg", 1, 6, 7, 3, 0);
    check("R6 neg value", res, 4'b1001);
    step("R4 dec", 1, 7, 7, 3, 0);
    step("R6 pass B", 1, 8, 7, 3, 0);
    step("R6 and", 1, 9, 7, 3, 0);
    step("R6 or", 1, 10, 7, 3, 0);
    step("R6 xor", 1, 11, 7, 3, 0);
    step("R7 shl", 1, 12, 7, 3, 1);
    check("R7 shl value", res, 4'b1110);
    step("R7 shr", 1, 13, 7, 3, 1);
    check("R7 shr value", res, 4'b0011);
    step("R8 parity odd", 1, 14, 7, 3, 0);
    check("R8 parity odd value", res, 4'b0001);
    step("R8 parity even", 1, 14, 4'b1001, 3, 1);
    check("R8 parity even value", res, 4'b0000);
    step("R9 zero", 1, 15, 15, 15, 1);

    // R4 wrap corners
    step("R4 inc wrap", 1, 1, 15, 0, 1);
    check("R4 inc wrap value", res, 4'b0000);
    step("R4 dec wrap", 1, 7, 0, 0, 1);
    check("R4 dec wrap value", res, 4'b1111);
    step("R4 sub borrow", 1, 4, 2, 9, 1);
    step("R6 neg zero", 1, 6, 0, 5, 0);
    step("R7 shr msb", 1, 13, 8, 0, 1);
    step("R7 shl msb drop", 1, 12, 9, 0, 1);

    // R2 hold with enable low and changing inputs
    step("R3 load before hold", 1, 2, 5, 4, 0);
    for (int k = 0; k < 6; k++) step("R2 hold", 0, k * 2, k + 3, 15 - k, k % 2);

    // R3 sweep of every code, both carry values, random operands
    for (int rep = 0; rep < 40; rep++)
      for (int f = 0; f < 16; f++)
        for (int c = 0; c < 2; c++)
          step("R3 sweep", 1, f, $urandom_range(0, 15), $urandom_range(0, 15), c);

    // R1 reset mid-run
    step("R3 load before reset", 1, 0, 12, 0, 0);
    rst = 1'b1;
    @(negedge clk);
    expect_q = 4'h0;
    check("R1 reset mid-run", res, 4'h0);
    rst = 1'b0;
    step("R3 after reset", 1, 11, 10, 6, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule